// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out and takes back power-of-two blocks of a memory region. The region is measured in minimum-size units: 64 of them by default. A block of order k spans 2^k units and always starts on a multiple of 2^k. The orders run from 0 up to `NUM_ORDERS-1`. Addresses on the ports count minimum-size units, so the caller scales them to bytes.

For each order, the allocator keeps a set of free blocks. A priority encoder scans this set and always picks the lowest-addressed free block. Each order below the top one also keeps one parity bit per buddy pair. Two blocks are buddies when their block numbers differ only in bit 0. A 0 in the pair bit means both buddies are free or both are allocated. A 1 means exactly one of them is allocated.

An allocation looks upward from the requested order for the first order that has a free block. It then splits that block down one order per clock, freeing the upper half at each order it passes. A release flips the pair bit and reads it back to decide whether to merge with the buddy or to stop. Each step of the walk takes one clock cycle. Only one operation runs at a time, under a busy/done handshake. At reset, every block of the top order is free and every pair bit is 0.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `addr_out` are 0. Every top-order block is free, so top-order allocations return 0, 8, 16, ... 56 in that order.
- R2: An allocation of order d returns the lowest-addressed free block at the smallest order x ≥ d that has one. When x = d, `addr_out` is that block's unit address, aligned to 2^d.
- R3: When x > d, the allocation takes the lowest half at each lower order and frees the upper half. The next allocation of order y in [d, x-1] therefore returns the lowest-addressed block among the halves just freed, where no lower-addressed free block of order y exists.
- R4: If no order at or above d holds a free block, the allocation ends with `fail`=1. The free sets and pair bits are left exactly as they were.
- R5: A release of block (a, d) frees the block. While the buddy is also free, the two merge and the process repeats one order up. `addr_out` then gives the start of the final merged block. Releasing everything makes the whole region allocatable again from address 0.
- R6: A release whose buddy is still allocated stops at that order after one cycle. The buddy stays allocated.
- R7: A release fails, with `fail`=1, no state change and one busy cycle, when either of these holds:
  - the address is not aligned to 2^d;
  - the block is already free at order d.
- R8: A `start` that is sampled while `busy` is 0 begins an operation. `op_free`=0 means allocate and 1 means release. `busy` is 1 from the next cycle until the result is ready. `done` is then 1 for exactly one cycle, with `busy`=0. A `start` seen while `busy`=1 is ignored.
- R9: The number of busy cycles is fixed by the walk:
  - a successful allocation takes 2(x-d)+1 cycles;
  - a failed allocation takes `NUM_ORDERS`-d cycles;
  - a release takes one cycle per order visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_free | input | 1 | 0 = allocate, 1 = release |
| order_in | input | OW | Requested block order |
| addr_in | input | ADDR_W | Unit address of the block to release |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | Result: operation refused (valid with done) |
| addr_out | output | ADDR_W | Allocated block, or merged block after release |

## Verification
Several corner cases are driven on purpose:
- A first small allocation from a fresh reset has to walk all three splits. A design that set the wrong half free, or skipped the pair flip, would return a repeated or out-of-order address on the next request.
- A release is made while the buddy is still held. A release is then made that cascades two levels. A design that read the pair bit before the flip, instead of after, would merge too far here or not at all.
- A double release, a misaligned release, and allocations against an exhausted region must all come back refused. Any stray write on those paths shows up as a wrong address in the random traffic that follows.
- Busy-cycle counts catch a walk that skips or repeats an order.
- A start pulse during an operation checks that nothing is launched twice.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEARCH = 2'd1,
      ST_SPLIT  = 2'd2,
      ST_MERGE  = 2'd3
   } buddy_state_t;

   // width of an index into n items, never below 1
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/buddy_first_set.sv
module buddy_first_set #(
   parameter int W  = 8,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);

   // lowest set bit wins: scan from the top so the lowest overwrites
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

endmodule

// File: rtl/buddy_level.sv
module buddy_level #(
   parameter int BLOCKS = 8,
   parameter int ADDR_W = 6,
   parameter bit IS_TOP = 1'b0,
   localparam int MAXB  = 2 ** ADDR_W,
   localparam int MAXP  = MAXB / 2,
   localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [ADDR_W-1:0] set_idx,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_idx,
   input  logic              flip_en,
   input  logic [ADDR_W-1:0] flip_idx,
   output logic [MAXB-1:0]   free_vec,
   output logic [MAXP-1:0]   pair_vec,
   output logic              any_free,
   output logic [ADDR_W-1:0] first_idx
);

   if (BLOCKS < 2 || (2 ** BW) != BLOCKS || BLOCKS > MAXB) begin : g_bad_blocks
      $error("buddy_level: BLOCKS must be a power of two in [2, 2**ADDR_W]");
   end

   logic [BLOCKS-1:0] free_q;
   logic [BW-1:0]     enc_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= IS_TOP ? {BLOCKS{1'b1}} : {BLOCKS{1'b0}};
      end else begin
         if (clr_en) free_q[clr_idx[BW-1:0]] <= 1'b0;
         if (set_en) free_q[set_idx[BW-1:0]] <= 1'b1;
      end
   end

   buddy_first_set #(.W(BLOCKS)) u_enc (
      .vec (free_q),
      .any (any_free),
      .idx (enc_idx)
   );

   always_comb begin
      free_vec               = '0;
      free_vec[BLOCKS-1:0]   = free_q;
      first_idx              = '0;
      first_idx[BW-1:0]      = enc_idx;
   end

   if (IS_TOP) begin : g_top
      // the largest order never merges, so it keeps no pair state
      assign pair_vec = '0;

      assert_top_no_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !flip_en);
   end else begin : g_pairs
      localparam int PAIRS = BLOCKS / 2;
      logic [PAIRS-1:0] pair_q;

      always_ff @(posedge clk) begin
         if (!rst_n) pair_q <= '0;
         else if (flip_en) pair_q[flip_idx[BW-1:1]] <= ~pair_q[flip_idx[BW-1:1]];
      end

      always_comb begin
         pair_vec              = '0;
         pair_vec[PAIRS-1:0]   = pair_q;
      end

      // a freshly split upper half is always allocated-parity: bit becomes 1
      assert_split_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (flip_en && set_en && set_idx == (flip_idx | ADDR_W'(1)) && flip_idx[0] == 1'b0
          && !clr_en)
         |=> pair_q[$past(flip_idx[BW-1:1])]);
   end

   // never mark free a block that is already free, never take a block that is not
   assert_set_was_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !free_q[set_idx[BW-1:0]]);

   assert_clr_was_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> free_q[clr_idx[BW-1:0]]);

endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
   import buddy_pkg::*;
#(
   parameter int MIN_BLOCKS = 64,
   parameter int NUM_ORDERS = 4,
   localparam int ADDR_W    = $clog2(MIN_BLOCKS),
   localparam int OW        = (NUM_ORDERS > 1) ? $clog2(NUM_ORDERS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op_free,
   input  logic [OW-1:0]     order_in,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] addr_out
);

   localparam int TOPO = NUM_ORDERS - 1;
   localparam int MAXP = MIN_BLOCKS / 2;
   localparam int NSEL = 2 ** OW;

   function automatic logic [NSEL-1:0] valid_orders();
      logic [NSEL-1:0] m;
      m = '0;
      for (int k = 0; k < NSEL; k++) m[k] = (k < NUM_ORDERS);
      return m;
   endfunction

   localparam logic [NSEL-1:0] ORD_OK = valid_orders();

   if ((2 ** ADDR_W) != MIN_BLOCKS || MIN_BLOCKS < 4) begin : g_bad_region
      $error("buddy_alloc: MIN_BLOCKS must be a power of two, at least 4");
   end
   if (NUM_ORDERS < 2 || (MIN_BLOCKS >> (NUM_ORDERS - 1)) < 2) begin : g_bad_orders
      $error("buddy_alloc: need two or more orders and at least two top-order blocks");
   end

   // ---------------------------------------------------------------- state
   buddy_state_t      state_q, state_d;
   logic [OW-1:0]     cur_q, cur_d;
   logic [ADDR_W-1:0] blk_q, blk_d;
   logic [OW-1:0]     req_q;
   logic [ADDR_W-1:0] areq_q;
   logic              op_q;
   logic              chk_q;
   logic              done_q, done_d;
   logic              fail_q, fail_d;
   logic [ADDR_W-1:0] aout_q, aout_d;

   // shared update buses: at most one order written per kind per cycle
   logic              set_go, clr_go, flip_go;
   logic [OW-1:0]     set_ord, clr_ord, flip_ord;
   logic [ADDR_W-1:0] set_idx, clr_idx, flip_idx;

   logic [MIN_BLOCKS-1:0] free_vec  [NUM_ORDERS];
   logic [MAXP-1:0]       pair_vec  [NUM_ORDERS];
   logic [ADDR_W-1:0]     first_idx [NUM_ORDERS];
   logic [NUM_ORDERS-1:0] any_free;

   // ---------------------------------------------------------------- levels
   for (genvar k = 0; k < NUM_ORDERS; k++) begin : g_ord
      buddy_level #(
         .BLOCKS (MIN_BLOCKS >> k),
         .ADDR_W (ADDR_W),
         .IS_TOP (k == TOPO)
      ) u_lvl (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_en    (set_go  && set_ord  == OW'(k)),
         .set_idx   (set_idx),
         .clr_en    (clr_go  && clr_ord  == OW'(k)),
         .clr_idx   (clr_idx),
         .flip_en   (flip_go && flip_ord == OW'(k)),
         .flip_idx  (flip_idx),
         .free_vec  (free_vec[k]),
         .pair_vec  (pair_vec[k]),
         .any_free  (any_free[k]),
         .first_idx (first_idx[k])
      );
   end

   // ---------------------------------------------------------------- control
   logic              ord_ok, cur_top, misaligned;
   logic [ADDR_W-1:0] amask;

   always_comb begin
      ord_ok     = ORD_OK[cur_q];
      cur_top    = (cur_q == OW'(TOPO));
      amask      = (ADDR_W'(1) << cur_q) - ADDR_W'(1);
      misaligned = (areq_q & amask) != '0;
   end

   always_comb begin
      state_d  = state_q;
      cur_d    = cur_q;
      blk_d    = blk_q;
      done_d   = 1'b0;
      fail_d   = fail_q;
      aout_d   = aout_q;
      set_go   = 1'b0;
      clr_go   = 1'b0;
      flip_go  = 1'b0;
      set_ord  = cur_q;
      clr_ord  = cur_q;
      flip_ord = cur_q;
      set_idx  = blk_q;
      clr_idx  = blk_q;
      flip_idx = blk_q;

      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_d = op_free ? ST_MERGE : ST_SEARCH;
               cur_d   = order_in;
               blk_d   = addr_in >> order_in;
            end
         end

         ST_SEARCH: begin
            if (!ord_ok) begin
               state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b1;
            end else if (any_free[cur_q]) begin
               clr_go  = 1'b1;
               clr_idx = first_idx[cur_q];
               if (!cur_top) begin
                  flip_go  = 1'b1;
                  flip_idx = first_idx[cur_q];
               end
               if (cur_q == req_q) begin
                  state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b0;
                  aout_d  = first_idx[cur_q] << cur_q;
               end else begin
                  state_d = ST_SPLIT;
                  cur_d   = cur_q - OW'(1);
                  blk_d   = first_idx[cur_q] << 1;
               end
            end else if (cur_top) begin
               state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b1;
            end else begin
               cur_d = cur_q + OW'(1);
            end
         end

         ST_SPLIT: begin
            // keep the lower half, hand the upper half to this order's free set
            flip_go = 1'b1;
            set_go  = 1'b1;
            set_idx = blk_q | ADDR_W'(1);
            if (cur_q == req_q) begin
               state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b0;
               aout_d  = blk_q << cur_q;
            end else begin
               cur_d = cur_q - OW'(1);
               blk_d = blk_q << 1;
            end
         end

         ST_MERGE: begin
            if (chk_q && (!ord_ok || misaligned || free_vec[cur_q][blk_q])) begin
               state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b1;
            end else if (cur_top) begin
               set_go  = 1'b1;
               state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b0;
               aout_d  = blk_q << cur_q;
            end else begin
               flip_go = 1'b1;
               if (pair_vec[cur_q][blk_q[ADDR_W-1:1]]) begin
                  // bit falls to 0: buddy was free, absorb it and climb
                  clr_go  = 1'b1;
                  clr_idx = blk_q ^ ADDR_W'(1);
                  cur_d   = cur_q + OW'(1);
                  blk_d   = blk_q >> 1;
               end else begin
                  // bit rises to 1: buddy still held, stop here
                  set_go  = 1'b1;
                  state_d = ST_IDLE; done_d = 1'b1; fail_d = 1'b0;
                  aout_d  = blk_q << cur_q;
               end
            end
         end

         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         blk_q   <= '0;
         req_q   <= '0;
         areq_q  <= '0;
         op_q    <= 1'b0;
         chk_q   <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         aout_q  <= '0;
      end else begin
         state_q <= state_d;
         cur_q   <= cur_d;
         blk_q   <= blk_d;
         done_q  <= done_d;
         fail_q  <= fail_d;
         aout_q  <= aout_d;
         chk_q   <= (state_q == ST_IDLE) && start;
         if (state_q == ST_IDLE && start) begin
            req_q  <= order_in;
            areq_q <= addr_in;
            op_q   <= op_free;
         end
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign fail     = fail_q;
   assign addr_out = aout_q;

   // ---------------------------------------------------------------- checks
   assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_alloc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail && !op_q) |-> ((addr_out & ((ADDR_W'(1) << req_q) - ADDR_W'(1))) == '0));

   // a refused operation leaves every free set as it was when it began
   logic [MIN_BLOCKS-1:0] snap_q [NUM_ORDERS];
   for (genvar k = 0; k < NUM_ORDERS; k++) begin : g_snap
      always_ff @(posedge clk) begin
         if (!rst_n)                        snap_q[k] <= '0;
         else if (state_q == ST_IDLE && start) snap_q[k] <= free_vec[k];
      end
      assert_fail_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (done && fail) |-> (free_vec[k] == snap_q[k]));
   end

endmodule

// File: tb/tb_buddy_alloc.sv
module tb_buddy_alloc;
   localparam int NB = 64;
   localparam int NO = 4;
   localparam int AW = 6;
   localparam int OW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          op_free = 1'b0;
   logic [OW-1:0] order_in = '0;
   logic [AW-1:0] addr_in = '0;
   logic          busy, done, fail;
   logic [AW-1:0] addr_out;

   buddy_alloc #(.MIN_BLOCKS(NB), .NUM_ORDERS(NO)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_free(op_free),
      .order_in(order_in), .addr_in(addr_in), .busy(busy), .done(done),
      .fail(fail), .addr_out(addr_out)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   // reference: free blocks per order, plus list of live allocations
   logic [NB-1:0] mf [NO];
   int al_a [64];
   int al_o [64];
   int n_al = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void m_alloc(input int d, output bit f, output int a, output int lat);
      f = 1'b1; a = 0; lat = NO - d;
      for (int x = d; x < NO; x++) begin
         int idx = -1;
         for (int i = 0; i < (NB >> x); i++) begin
            if (mf[x][i]) begin idx = i; break; end
         end
         if (idx >= 0) begin
            mf[x][idx] = 1'b0;
            for (int y = x - 1; y >= d; y--) begin
               idx = idx * 2;
               mf[y][idx + 1] = 1'b1;
            end
            f = 1'b0; a = idx << d; lat = 2 * (x - d) + 1;
            return;
         end
      end
   endfunction

   function automatic void m_free(input int a, input int d, output bit f, output int na,
                                  output int lat);
      int blk, x;
      if ((a % (1 << d)) != 0 || mf[d][a >> d]) begin
         f = 1'b1; na = 0; lat = 1;
         return;
      end
      f = 1'b0; blk = a >> d; x = d;
      forever begin
         if (x == NO - 1) begin mf[x][blk] = 1'b1; break; end
         if (mf[x][blk ^ 1]) begin
            mf[x][blk ^ 1] = 1'b0; blk = blk >> 1; x++;
         end else begin
            mf[x][blk] = 1'b1; break;
         end
      end
      na = blk << x; lat = x - d + 1;
   endfunction

   task automatic run(input bit opf, input int ord, input int a,
                      output bit f, output int ao, output int lat);
      @(negedge clk);
      start = 1'b1; op_free = opf; order_in = OW'(ord); addr_in = AW'(a);
      @(negedge clk);
      start = 1'b0; lat = 0;
      for (int g = 0; g < 100; g++) begin
         if (done) break;
         if (busy) lat++;
         @(negedge clk);
      end
      f = fail; ao = int'(addr_out);
   endtask

   task automatic do_alloc(input int d, input string tag);
      bit ef, af; int ea, aa, el, al;
      m_alloc(d, ef, ea, el);
      run(1'b0, d, 0, af, aa, al);
      check(af == ef, ef ? "R4 fail flag" : {tag, " fail flag"}, af, ef);
      if (!ef) check(aa == ea, {tag, " address"}, aa, ea);
      check(al == el, "R9 busy cycles", al, el);
      if (!ef && !af) begin al_a[n_al] = ea; al_o[n_al] = d; n_al++; end
   endtask

   task automatic do_free_at(input int i, input string tag);
      bit ef, af; int ea, aa, el, al, a, d;
      a = al_a[i]; d = al_o[i];
      n_al--; al_a[i] = al_a[n_al]; al_o[i] = al_o[n_al];
      m_free(a, d, ef, ea, el);
      run(1'b1, d, a, af, aa, al);
      check(af == 1'b0, {tag, " fail flag"}, af, 0);
      check(aa == ea, {tag, " merged address"}, aa, ea);
      check(al == el, {tag, " busy cycles"}, al, el);
   endtask

   task automatic do_free(input int a, input int d, input string tag);
      for (int i = 0; i < n_al; i++) begin
         if (al_a[i] == a && al_o[i] == d) begin do_free_at(i, tag); return; end
      end
      check(1'b0, "bench list", a, d);
   endtask

   task automatic do_bad_free(input int a, input int d);
      bit ef, af; int ea, aa, el, al;
      m_free(a, d, ef, ea, el);
      run(1'b1, d, a, af, aa, al);
      check(af == 1'b1, "R7 refused release", af, 1);
      check(al == 1, "R7 busy cycles", al, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      bit ef; int ea, el, lat;
      void'($urandom(32'd24681));
      for (int k = 0; k < NO; k++) mf[k] = '0;
      mf[NO-1][(NB >> (NO-1)) - 1:0] = '1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs out of reset
      check(busy == 1'b0, "R1 busy", busy, 0);
      check(done == 1'b0, "R1 done", done, 0);
      check(fail == 1'b0, "R1 fail", fail, 0);
      check(addr_out == '0, "R1 addr_out", addr_out, 0);

      // R8: stray start during an allocation that splits three times (R3)
      m_alloc(0, ef, ea, el);
      @(negedge clk);
      start = 1'b1; op_free = 1'b0; order_in = '0; addr_in = '0;
      @(negedge clk);
      lat = 0;
      check(busy == 1'b1, "R8 busy after start", busy, 1);
      if (busy) lat++;
      op_free = 1'b1; addr_in = AW'(1);
      @(negedge clk);
      start = 1'b0;
      for (int g = 0; g < 100; g++) begin
         if (done) break;
         if (busy) lat++;
         @(negedge clk);
      end
      check(fail == 1'b0, "R2 first alloc fail", fail, 0);
      check(int'(addr_out) == ea, "R2 first alloc address", addr_out, ea);
      check(lat == el, "R9 three-split cycles", lat, el);
      check(busy == 1'b0, "R8 busy low with done", busy, 0);
      al_a[n_al] = ea; al_o[n_al] = 0; n_al++;
      for (int g = 0; g < 3; g++) begin
         @(negedge clk);
         check(!done && !busy, "R8 ignored start", {done, busy}, 0);
      end

      do_alloc(0, "R3");          // upper half at order 0 -> 1
      do_alloc(1, "R3");          // -> 2
      do_alloc(2, "R3");          // -> 4
      do_alloc(3, "R1");          // -> 8
      do_free(1, 0, "R6");        // buddy 0 held: stop
      do_bad_free(1, 0);          // double release
      do_bad_free(3, 1);          // misaligned
      do_free(0, 0, "R5");        // merges to order 1, stops against block 2
      for (int i = 0; i < 7; i++) do_alloc(3, "R1");  // 16..56, then refusal
      do_alloc(0, "R4");          // state intact after refusal
      do_alloc(2, "R4");          // nothing larger left: refused

      // random traffic against the reference
      for (int it = 0; it < 500; it++) begin
         int r = int'($urandom % 16);
         if (r == 0) begin
            int d = 1 + int'($urandom % 3);
            do_bad_free(int'($urandom % NB) | 1, d);
         end else if (n_al == 0 || r < 8) begin
            do_alloc(int'($urandom % NO), "R2");
         end else begin
            do_free_at(int'($urandom % n_al), "R5");
         end
      end

      while (n_al > 0) do_free_at(n_al - 1, "R5");
      do_alloc(3, "R5");
      check(al_a[0] == 0, "R5 region whole again", al_a[0], 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule